// File: doc/BRIEF.md
# Configuration Transfer Release Controller

This block decides the moment at which a freshly loaded shadow configuration is committed to the live configuration. It watches an end-of-load strobe from the configuration loader, two asynchronous lines from outside the chip (an arm line and a trigger line), internal arm and trigger strobes, and a flag that reports every internal clock as aligned. When its release policy is met, it emits a single execute pulse on the array clock that starts the copy.

A small mode register chooses one of four release policies. In the first, the end-of-load strobe releases immediately. In the second, the end-of-load strobe arms the block and an external trigger edge fires it. In the third, one of the two external lines is used and the other role is taken by an internal strobe. In the fourth, the end-of-load strobe arms the block and the first aligned-clock cycle fires it. Arming is one-shot: firing clears the armed state, and later triggers do nothing until the block is armed again.

External lines pass through a synchronizer of `SYNC_STAGES` flops. Their rising edges are then detected in the array clock domain.

Top module: `cfg_xfer_release`

## Requirements
- R1: After an active-low reset, `execute` and `armed` are 0 and the mode is immediate release (code 0, external-role select 0).
- R2: In mode code 0, a rising edge on `endOfStream` drives `execute` high in the cycle after the edge that samples it. `armed` stays 0, and the external and internal trigger inputs have no effect.
- R3: In mode code 1, a rising edge on `endOfStream` sets `armed`. A later rising edge on `extTrig` then fires `execute`.
- R4: In mode code 2 with `selArmIn` = 0, only an `intArm` strobe arms the block and only a rising edge on `extTrig` fires it. `intTrig` and `endOfStream` have no effect.
- R5: In mode code 2 with `selArmIn` = 1, only a rising edge on `extArm` arms the block and only an `intTrig` strobe fires it. `extTrig` has no effect.
- R6: In mode code 3, a rising edge on `endOfStream` sets `armed`. The first armed cycle with `clocksAligned` high fires `execute`.
- R7: `execute` is high for exactly one cycle per release, and `armed` is 0 while `execute` is high. Holding a trigger or the end-of-load strobe high, or giving further trigger edges, produces no further pulse until the block is re-armed.
- R8: A trigger that arrives while `armed` is 0 never produces `execute`. This applies in modes 1, 2 and 3.
- R9: A cycle with `modeWe` high loads `modeIn` and `selArmIn`, clears `armed` and suppresses any release in that cycle.
- R10: A rising level on `extArm` or `extTrig` takes effect on `armed` or `execute` `SYNC_STAGES`+1 clock edges after it appears. Strobes on `endOfStream`, `intArm` and `intTrig` take effect one edge after they appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWe | input | 1 | Write strobe for the mode register |
| modeIn | input | 2 | Mode code: 0 immediate, 1 event, 2 arm-plus-trigger, 3 clock-aligned |
| selArmIn | input | 1 | In mode 2: 1 means the external line is the arm, 0 means it is the trigger |
| endOfStream | input | 1 | End-of-load indication from the configuration loader (rising edge used) |
| extArm | input | 1 | Asynchronous external arm line |
| extTrig | input | 1 | Asynchronous external trigger line |
| intArm | input | 1 | Internal arm strobe, synchronous |
| intTrig | input | 1 | Internal trigger strobe, synchronous |
| clocksAligned | input | 1 | High while every internal clock is aligned |
| execute | output | 1 | One-cycle transfer start pulse |
| armed | output | 1 | Block is armed and waiting for its trigger |

## Verification
A synchronous strobe or the end-of-load edge shows its result on `execute` or `armed` one clock edge later. An edge on an external line shows its result `SYNC_STAGES`+1 edges later, because it passes through the synchronizer stages and then the edge-detect register. When the driver presents a stimulus, it records the cycle index at which the resulting pulse is due, using these latencies. A monitor samples on the falling edge and compares every `execute` pulse with the head of that queue. A pulse with no matching entry, at the wrong index, or missing altogether is an error. The `armed` level is sampled at the falling edge that falls exactly at the computed latency, and one edge earlier where the synchronizer delay itself is under test.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int NUM_EXT = 2;
  localparam int EXT_ARM_IDX = 0;
  localparam int EXT_TRIG_IDX = 1;

  typedef enum logic [1:0] {
    MODE_AUTO    = 2'd0,
    MODE_EVENT   = 2'd1,
    MODE_ARMTRIG = 2'd2,
    MODE_CLKSYNC = 2'd3
  } xferMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setArm;
    logic clrArm;
    logic fire;
  } xferStrobe_t;

  // Edge events from datapath to control
  typedef struct packed {
    logic eosRise;
    logic extArmRise;
    logic extTrigRise;
  } evtFlags_t;

endpackage

// File: rtl/cfgx_sync.sv
module cfgx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chainQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= '0;
        else       chainQ <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= '0;
        else       chainQ <= {chainQ[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chainQ[STAGES-1];

endmodule

// File: rtl/cfgx_datapath.sv
module cfgx_datapath
  import cfgx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        endOfStream,
  input  logic        extArm,
  input  logic        extTrig,
  input  xferStrobe_t strobe,
  output evtFlags_t   evt,
  output logic        armedQ,
  output logic        executeQ
);

  logic [NUM_EXT-1:0] rawExt;
  logic [NUM_EXT-1:0] syncExt;
  logic [NUM_EXT-1:0] syncPrevQ;
  logic [NUM_EXT-1:0] extRise;
  logic               eosPrevQ;

  assign rawExt[EXT_ARM_IDX]  = extArm;
  assign rawExt[EXT_TRIG_IDX] = extTrig;

  // One synchronizer per external line
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_sync
    cfgx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawExt[g]),
      .dout (syncExt[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrevQ <= '0;
      eosPrevQ  <= 1'b0;
    end else begin
      syncPrevQ <= syncExt;
      eosPrevQ  <= endOfStream;
    end
  end

  assign extRise         = syncExt & ~syncPrevQ;
  assign evt.extArmRise  = extRise[EXT_ARM_IDX];
  assign evt.extTrigRise = extRise[EXT_TRIG_IDX];
  assign evt.eosRise     = endOfStream & ~eosPrevQ;

  // Arm latch: clear has priority so a release is always one-shot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               armedQ <= 1'b0;
    else if (strobe.clrArm)  armedQ <= 1'b0;
    else if (strobe.setArm)  armedQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) executeQ <= 1'b0;
    else       executeQ <= strobe.fire;
  end

  // R7: the pulse never stretches
  p_exec_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    executeQ |=> !executeQ);

  // R7: the arm latch is empty whenever a pulse is out
  p_disarm_on_fire_r7: assert property (@(posedge clk) disable iff (!rstN)
    executeQ |-> !armedQ);

endmodule

// File: rtl/cfgx_control.sv
module cfgx_control
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWe,
  input  logic [1:0]  modeIn,
  input  logic        selArmIn,
  input  evtFlags_t   evt,
  input  logic        intArm,
  input  logic        intTrig,
  input  logic        clocksAligned,
  input  logic        armedIn,
  output xferStrobe_t strobe,
  output xferMode_e   modeQ
);

  logic selArmQ;
  logic armSrc;
  logic trigSrc;
  logic autoFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_AUTO;
      selArmQ <= 1'b0;
    end else if (modeWe) begin
      modeQ   <= xferMode_e'(modeIn);
      selArmQ <= selArmIn;
    end
  end

  // Route arm and trigger sources according to the release policy
  always_comb begin
    armSrc   = 1'b0;
    trigSrc  = 1'b0;
    autoFire = 1'b0;
    case (modeQ)
      MODE_AUTO: begin
        autoFire = evt.eosRise;
      end
      MODE_EVENT: begin
        armSrc  = evt.eosRise;
        trigSrc = evt.extTrigRise;
      end
      MODE_ARMTRIG: begin
        if (selArmQ) begin
          armSrc  = evt.extArmRise;
          trigSrc = intTrig;
        end else begin
          armSrc  = intArm;
          trigSrc = evt.extTrigRise;
        end
      end
      MODE_CLKSYNC: begin
        armSrc  = evt.eosRise;
        trigSrc = clocksAligned;
      end
      default: begin
        armSrc   = 1'b0;
        trigSrc  = 1'b0;
        autoFire = 1'b0;
      end
    endcase
  end

  always_comb begin
    strobe.fire   = !modeWe && (autoFire || (armedIn && trigSrc));
    strobe.clrArm = modeWe || strobe.fire;
    strobe.setArm = !modeWe && armSrc;
  end

  // R2: immediate mode never holds an arm
  p_auto_unarmed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_AUTO) |-> !armedIn);

  // R9: a mode write leaves the block disarmed
  p_write_disarms_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeWe |=> !armedIn);

endmodule

// File: rtl/cfg_xfer_release.sv
module cfg_xfer_release
  import cfgx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWe,
  input  logic [1:0] modeIn,
  input  logic       selArmIn,
  input  logic       endOfStream,
  input  logic       extArm,
  input  logic       extTrig,
  input  logic       intArm,
  input  logic       intTrig,
  input  logic       clocksAligned,
  output logic       execute,
  output logic       armed
);

  xferStrobe_t strobe;
  evtFlags_t   evt;
  xferMode_e   modeQ;

  cfgx_control u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .modeWe        (modeWe),
    .modeIn        (modeIn),
    .selArmIn      (selArmIn),
    .evt           (evt),
    .intArm        (intArm),
    .intTrig       (intTrig),
    .clocksAligned (clocksAligned),
    .armedIn       (armed),
    .strobe        (strobe),
    .modeQ         (modeQ)
  );

  cfgx_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .endOfStream (endOfStream),
    .extArm      (extArm),
    .extTrig     (extTrig),
    .strobe      (strobe),
    .evt         (evt),
    .armedQ      (armed),
    .executeQ    (execute)
  );

  // R8: no release can come out of an unarmed non-immediate mode
  p_unarmed_no_exec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_AUTO && !armed) |=> !execute);

  // R9: a mode write suppresses the release of that cycle
  p_write_no_exec_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeWe |=> !execute);

  // R6: armed plus aligned clocks releases on the next edge
  p_clksync_fire_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_CLKSYNC && armed && clocksAligned && !modeWe) |=> execute);

endmodule

// File: tb/cfg_xfer_release_tb_top.sv
module cfg_xfer_release_tb_top;

  localparam int SYNC = 2;
  localparam int EXT_LAT = SYNC + 1;

  typedef struct {
    int    cyc;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWe = 1'b0;
  logic [1:0] modeIn = 2'd0;
  logic selArmIn = 1'b0;
  logic endOfStream = 1'b0;
  logic extArm = 1'b0;
  logic extTrig = 1'b0;
  logic intArm = 1'b0;
  logic intTrig = 1'b0;
  logic clocksAligned = 1'b0;
  logic execute;
  logic armed;

  int cyc = 0;
  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  cfg_xfer_release #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeIn(modeIn),
    .selArmIn(selArmIn), .endOfStream(endOfStream), .extArm(extArm),
    .extTrig(extTrig), .intArm(intArm), .intTrig(intTrig),
    .clocksAligned(clocksAligned), .execute(execute), .armed(armed)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every pulse with the scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (execute) begin
        testsRun++;
        if (expQ.size() == 0) begin
          testsFailed++;
          $display("FAIL R7/R8 unexpected execute at cycle %0d (actual 1, expected 0)", cyc);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          if (it.cyc != cyc) begin
            testsFailed++;
            $display("FAIL %s execute at cycle %0d, expected cycle %0d", it.tag, cyc, it.cyc);
          end
        end
      end else if (expQ.size() > 0 && expQ[0].cyc < cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        testsRun++;
        testsFailed++;
        $display("FAIL %s missing execute (actual 0, expected 1 at cycle %0d)", it.tag, it.cyc);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectAt(input int c, input string tag);
    expItem_t it;
    it.cyc = c;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic setMode(input logic [1:0] m, input logic sel);
    modeWe = 1'b1; modeIn = m; selArmIn = sel;
    step(1);
    modeWe = 1'b0;
    step(2);
  endtask

  task automatic pulseEos();
    endOfStream = 1'b1;
    step(1);
    endOfStream = 1'b0;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    checkBit("R1", "execute", execute, 1'b0);
    checkBit("R1", "armed", armed, 1'b0);

    // R2: triggers do nothing in immediate mode
    extTrig = 1'b1; intTrig = 1'b1;
    step(1);
    intTrig = 1'b0;
    step(4);
    extTrig = 1'b0;
    step(4);
    checkBit("R2", "armed", armed, 1'b0);

    // R2, R7: end-of-load held 3 cycles releases once
    endOfStream = 1'b1;
    expectAt(cyc + 1, "R2");
    step(3);
    endOfStream = 1'b0;
    step(4);
    checkBit("R2", "armed", armed, 1'b0);

    // Event mode
    setMode(2'd1, 1'b0);
    extTrig = 1'b1;          // R8: unarmed trigger
    step(3);
    extTrig = 1'b0;
    step(4);
    pulseEos();
    checkBit("R3", "armed after end-of-load", armed, 1'b1);
    extTrig = 1'b1;
    expectAt(cyc + EXT_LAT, "R3/R10");
    step(3);
    extTrig = 1'b0;
    step(3);
    checkBit("R7", "armed after release", armed, 1'b0);
    extTrig = 1'b1;          // R7: no second release
    step(3);
    extTrig = 1'b0;
    step(4);

    // Arm-plus-trigger, external line is trigger
    setMode(2'd2, 1'b0);
    pulseEos();
    checkBit("R4", "armed after end-of-load", armed, 1'b0);
    intTrig = 1'b1;
    step(1);
    intTrig = 1'b0;
    step(3);
    intArm = 1'b1;
    step(1);
    intArm = 1'b0;
    checkBit("R4", "armed after intArm", armed, 1'b1);
    intTrig = 1'b1;
    step(1);
    intTrig = 1'b0;
    step(3);
    checkBit("R4", "armed after intTrig", armed, 1'b1);
    extTrig = 1'b1;
    expectAt(cyc + EXT_LAT, "R4");
    step(3);
    extTrig = 1'b0;
    step(4);

    // Arm-plus-trigger, external line is arm
    setMode(2'd2, 1'b1);
    extArm = 1'b1;
    step(SYNC);
    checkBit("R10", "armed before sync latency", armed, 1'b0);
    step(1);
    checkBit("R5", "armed after extArm", armed, 1'b1);
    extArm = 1'b0;
    extTrig = 1'b1;
    step(3);
    extTrig = 1'b0;
    step(3);
    checkBit("R5", "armed after extTrig", armed, 1'b1);
    intTrig = 1'b1;
    expectAt(cyc + 1, "R5");
    step(1);
    intTrig = 1'b0;
    step(3);

    // Clock-aligned mode
    setMode(2'd3, 1'b0);
    pulseEos();
    checkBit("R6", "armed after end-of-load", armed, 1'b1);
    step(3);
    clocksAligned = 1'b1;
    expectAt(cyc + 1, "R6");
    step(4);
    checkBit("R7", "armed after aligned release", armed, 1'b0);
    clocksAligned = 1'b0;
    step(2);

    // R9: mode write clears arm and blocks the release
    pulseEos();
    checkBit("R9", "armed before write", armed, 1'b1);
    modeWe = 1'b1; modeIn = 2'd3; clocksAligned = 1'b1;
    step(1);
    modeWe = 1'b0;
    checkBit("R9", "armed after write", armed, 1'b0);
    step(4);
    clocksAligned = 1'b0;
    step(5);

    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      testsRun++;
      testsFailed++;
      $display("FAIL %s execute never seen (actual 0, expected 1 at cycle %0d)", it.tag, it.cyc);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired (actual hung, expected finished)");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule